// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block runs a complete test on a circuit in which only some of the flip-flops are on a scan chain. It drives two clock enables. One goes to the scanned flip-flops and one goes to the non-scanned flip-flops. It also drives a shift/capture select line, a serial scan-in bit and a strobe that applies primary-input values. It contains a small embedded circuit so the whole sequence can be observed at the ports. That circuit has a six-bit scan chain, a bank of non-scanned flip-flops that are clocked only in normal mode, and a primary-input register.

After a start pulse, the block first exercises the chain with a fixed two-zeros/two-ones pattern. It then walks through a register file of test vectors. Each vector is shifted in, its primary inputs are applied, and one normal-mode capture follows. The captured response leaves the chain while the next vector is shifted in. After the last vector, a final unload empties the chain. Every bit that leaves the chain is compared serially against an expected value, and any difference sets a sticky flag. A quiet cycle with both enables low comes before and after each capture. The select line switches only in those quiet cycles.

Top module: `pss_top`

## Requirements
- R1: While reset is held and after its release, busy, done, both clock enables, the strobe and the miscompare flag are low, and the select line `tc` is high.
- R2: A start pulse while idle raises busy on the next cycle. Busy stays high until done has been high for exactly one cycle and then falls. The run lasts (NVEC+2)·NSFF + 3·NVEC + 5 busy cycles.
- R3: Over one run, the scan clock enable is high for exactly (NVEC+2)·NSFF + NVEC + 4 cycles.
- R4: The functional clock enable is high for exactly NVEC cycles, one per vector. Each of those cycles also has the scan enable high and `tc` low (normal mode). Every other scan-enabled cycle has `tc` high (scan mode).
- R5: `tc` changes value only in a cycle in which both clock enables are low.
- R6: The first NSFF+4 scan-enabled cycles present scan-in bit k = bit 1 of k, which gives 0,0,1,1,0,0,…
- R7: Each vector load is NSFF scan cycles with the stimulus sent MSB first. The chain shifts toward its MSB, and `scan_out` is chain bit NSFF-1, so stimulus bit j ends in chain position j.
- R8: The strobe is high for one cycle right before each capture and loads the primary-input register from that vector's word. There are NVEC strobes per run.
- R9: At capture, the non-scanned bank takes chain XOR primary inputs, and the chain takes chain + non-scanned bank (mod 2^NSFF), both using values from before the edge. The non-scanned bank changes only at capture and keeps its value across runs.
- R10: The response to vector v leaves the chain MSB first during the load of vector v+1. The last response leaves during the final NSFF-cycle unload.
- R11: The miscompare flag is set when a chain-test bit (shift k ≥ NSFF, expected bit 1 of k−NSFF) or a response bit differs from its expected value. It stays set until the next accepted start, which clears it.
- R12: A start pulse while busy has no effect on the schedule.
- R13: A vector-memory word holds the stimulus in bits [NSFF-1:0], the primary inputs in bits [2·NSFF-1:NSFF] and the expected response in bits [3·NSFF-1:2·NSFF]. A write stores it at the address given on the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run (accepted only when idle) |
| vec_we | input | 1 | Vector-memory write strobe |
| vec_addr | input | AW | Vector-memory write address |
| vec_wdata | input | 3·NSFF | Vector word: expected, primary inputs, stimulus |
| scan_ce | output | 1 | Clock enable for scanned flip-flops |
| func_ce | output | 1 | Clock enable for non-scanned flip-flops |
| tc | output | 1 | High selects shift, low selects capture |
| scan_in | output | 1 | Serial bit entering the chain |
| pi_strobe | output | 1 | Applies the current vector's primary inputs |
| scan_out | output | 1 | Serial bit leaving the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| miscompare | output | 1 | Sticky response mismatch flag |

## Verification
The assertions check the following on every cycle:
- capture happens in normal mode, and scan-only cycles have `tc` high;
- `tc` never changes while an enable is active;
- a capture always follows the strobe;
- done is a single pulse inside busy;
- the scan-enable count equals the closed-form total when done fires.

Some behaviour can only be shown by the bench's scenarios, where a model of the embedded circuit supplies the expected values:
- the order of the chain pattern;
- the MSB-first stimulus and response streams;
- the capture arithmetic;
- that the non-scanned bank persists across runs;
- that a deliberately wrong expected bit sets the flag, which then stays set until the next start clears it.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAIN,
    ST_LOAD,
    ST_GAPA,
    ST_CAPT,
    ST_GAPB,
    ST_UNLOAD,
    ST_FIN
  } pss_state_e;
endpackage

// File: rtl/pss_vecmem.sv
`timescale 1ns/1ps
module pss_vecmem #(
  parameter int NSFF = 6,
  parameter int NVEC = 4,
  localparam int AW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int WW = 3 * NSFF
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [WW-1:0]   wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [NSFF-1:0] stim,
  output logic [NSFF-1:0] piv,
  output logic [NSFF-1:0] expd
);
  logic [WW-1:0] mem [NVEC];

  // R13: plain register file, no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    stim = mem[raddr_a][NSFF-1:0];
    piv  = mem[raddr_a][2*NSFF-1:NSFF];
    expd = mem[raddr_b][3*NSFF-1:2*NSFF];
  end
endmodule

// File: rtl/pss_cut.sv
`timescale 1ns/1ps
module pss_cut #(
  parameter int NSFF = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_ce,
  input  logic            func_ce,
  input  logic            tc,
  input  logic            si,
  input  logic            pi_strobe,
  input  logic [NSFF-1:0] pi_val,
  output logic            so
);
  logic [NSFF-1:0] chain_q, chain_d;
  logic [NSFF-1:0] bank_q, bank_d;
  logic [NSFF-1:0] pin_q, pin_d;

  always_comb begin
    chain_d = chain_q;
    bank_d  = bank_q;
    pin_d   = pin_q;
    if (scan_ce) chain_d = tc ? {chain_q[NSFF-2:0], si} : chain_q + bank_q; // R7, R9
    if (func_ce) bank_d = chain_q ^ pin_q;                                   // R9
    if (pi_strobe) pin_d = pi_val;                                            // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      bank_q  <= '0;
      pin_q   <= '0;
    end else begin
      chain_q <= chain_d;
      bank_q  <= bank_d;
      pin_q   <= pin_d;
    end
  end

  assign so = chain_q[NSFF-1];
endmodule

// File: rtl/pss_seq.sv
`timescale 1ns/1ps
module pss_seq
  import pss_pkg::*;
#(
  parameter int NSFF = 6,
  parameter int NVEC = 4,
  localparam int AW  = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int CW  = $clog2(NSFF + 4),
  localparam int IW  = $clog2(NSFF),
  localparam int CE_TOTAL = (NVEC + 2) * NSFF + NVEC + 4,
  localparam int EW  = $clog2(CE_TOTAL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            so,
  input  logic [NSFF-1:0] stim,
  input  logic [NSFF-1:0] expd,
  output logic [AW-1:0]   vec_idx,
  output logic [AW-1:0]   exp_idx,
  output logic            scan_ce,
  output logic            func_ce,
  output logic            tc,
  output logic            scan_in,
  output logic            pi_strobe,
  output logic            busy,
  output logic            done,
  output logic            miscompare
);
  pss_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] vec_q, vec_d;
  logic          mis_q, mis_d;
  logic [IW-1:0] bidx;
  logic          cmp_en, cmp_bit;

  assign bidx = IW'(NSFF - 1) - IW'(cnt_q);

  // Moore decode of the strobes
  always_comb begin
    scan_ce   = (state_q == ST_CHAIN) || (state_q == ST_LOAD) ||
                (state_q == ST_CAPT)  || (state_q == ST_UNLOAD);
    func_ce   = (state_q == ST_CAPT);
    tc        = !((state_q == ST_GAPA) || (state_q == ST_CAPT));
    pi_strobe = (state_q == ST_GAPA);
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_FIN);
    case (state_q)
      ST_CHAIN: scan_in = (cnt_q & CW'(2)) != '0;   // R6
      ST_LOAD:  scan_in = stim[bidx];               // R7
      default:  scan_in = 1'b0;
    endcase
  end

  // serial compare (R11)
  always_comb begin
    cmp_en  = 1'b0;
    cmp_bit = expd[bidx];
    case (state_q)
      ST_CHAIN: begin
        cmp_en  = cnt_q >= CW'(NSFF);
        cmp_bit = ((cnt_q - CW'(NSFF)) & CW'(2)) != '0;
      end
      ST_LOAD:   cmp_en = (vec_q != '0);
      ST_UNLOAD: cmp_en = 1'b1;
      default:   cmp_en = 1'b0;
    endcase
  end

  assign vec_idx = vec_q;
  assign exp_idx = (state_q == ST_LOAD) ? vec_q - AW'(1) : vec_q;
  assign miscompare = mis_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    vec_d   = vec_q;
    mis_d   = mis_q;
    case (state_q)
      ST_IDLE: if (start) begin          // R12: start only honoured here
        state_d = ST_CHAIN;
        cnt_d   = '0;
        vec_d   = '0;
        mis_d   = 1'b0;
      end
      ST_CHAIN: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(NSFF + 3)) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end
      end
      ST_LOAD: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(NSFF - 1)) begin
          state_d = ST_GAPA;
          cnt_d   = '0;
        end
      end
      ST_GAPA: state_d = ST_CAPT;
      ST_CAPT: state_d = ST_GAPB;
      ST_GAPB: begin
        cnt_d = '0;
        if (vec_q == AW'(NVEC - 1)) state_d = ST_UNLOAD;
        else begin
          state_d = ST_LOAD;
          vec_d   = vec_q + AW'(1);
        end
      end
      ST_UNLOAD: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(NSFF - 1)) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
    if (cmp_en && (so != cmp_bit)) mis_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vec_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vec_q   <= vec_d;
      mis_q   <= mis_d;
    end
  end

  // scan-enable tally for the closed-form check
  logic [EW-1:0] ce_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_cnt <= '0;
    else if (!busy && start) ce_cnt <= '0;
    else if (scan_ce) ce_cnt <= ce_cnt + EW'(1);
  end

  a_r3_ce_total: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_cnt == EW'(CE_TOTAL)));
  a_r4_capture_normal: assert property (@(posedge clk) disable iff (!rst_n)
    func_ce |-> (scan_ce && !tc));
  a_r4_shift_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ce && !func_ce) |-> tc);
  a_r5_tc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != $past(tc)) |-> (!scan_ce && !func_ce));
  a_r8_strobe_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pi_strobe |=> func_ce);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r2_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: rtl/pss_top.sv
`timescale 1ns/1ps
module pss_top #(
  parameter int NSFF = 6,
  parameter int NVEC = 4,
  localparam int AW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int WW = 3 * NSFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          vec_we,
  input  logic [AW-1:0] vec_addr,
  input  logic [WW-1:0] vec_wdata,
  output logic          scan_ce,
  output logic          func_ce,
  output logic          tc,
  output logic          scan_in,
  output logic          pi_strobe,
  output logic          scan_out,
  output logic          busy,
  output logic          done,
  output logic          miscompare
);
  logic [1:0]      rst_pipe;
  logic            rst_int;
  logic [AW-1:0]   vec_idx, exp_idx;
  logic [NSFF-1:0] stim, piv, expd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  pss_vecmem #(.NSFF(NSFF), .NVEC(NVEC)) u_mem (
    .clk(clk), .we(vec_we), .waddr(vec_addr), .wdata(vec_wdata),
    .raddr_a(vec_idx), .raddr_b(exp_idx),
    .stim(stim), .piv(piv), .expd(expd)
  );

  pss_seq #(.NSFF(NSFF), .NVEC(NVEC)) u_seq (
    .clk(clk), .rst_n(rst_int), .start(start), .so(scan_out),
    .stim(stim), .expd(expd), .vec_idx(vec_idx), .exp_idx(exp_idx),
    .scan_ce(scan_ce), .func_ce(func_ce), .tc(tc), .scan_in(scan_in),
    .pi_strobe(pi_strobe), .busy(busy), .done(done), .miscompare(miscompare)
  );

  pss_cut #(.NSFF(NSFF)) u_cut (
    .clk(clk), .rst_n(rst_int), .scan_ce(scan_ce), .func_ce(func_ce),
    .tc(tc), .si(scan_in), .pi_strobe(pi_strobe), .pi_val(piv), .so(scan_out)
  );
endmodule

// File: tb/pss_top_test.sv
`timescale 1ns/1ps
module pss_top_test;
  localparam int N  = 6;
  localparam int V  = 4;
  localparam int AW = 2;
  localparam int CE_TOTAL   = (V + 2) * N + V + 4;
  localparam int BUSY_TOTAL = CE_TOTAL + 2 * V + 1;
  // rows: {primary inputs, stimulus}
  localparam logic [2*N-1:0] TAB [V] = '{
    {6'h2A, 6'h15}, {6'h3F, 6'h01}, {6'h00, 6'h3E}, {6'h11, 6'h2C}
  };

  logic clk, rst_n, start, vec_we;
  logic [AW-1:0]  vec_addr;
  logic [3*N-1:0] vec_wdata;
  logic scan_ce, func_ce, tc, scan_in, pi_strobe, scan_out, busy, done, miscompare;

  pss_top #(.NSFF(N), .NVEC(V)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_we(vec_we),
    .vec_addr(vec_addr), .vec_wdata(vec_wdata), .scan_ce(scan_ce),
    .func_ce(func_ce), .tc(tc), .scan_in(scan_in), .pi_strobe(pi_strobe),
    .scan_out(scan_out), .busy(busy), .done(done), .miscompare(miscompare)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_total = 0, n_fail = 0;
  logic [N-1:0] nmod, expv [V], resp_got [V], stim_got [V];
  int ce_n, fn_n, busy_n, strobe_n, tc_bad, mode_bad, strobe_bad, chain_bad;
  bit timed_out, mis_first;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of the embedded circuit (R9) and memory load (R13)
  task automatic load_vectors(input int bad_v);
    for (int v = 0; v < V; v++) begin
      expv[v] = TAB[v][N-1:0] + nmod;
      nmod    = TAB[v][N-1:0] ^ TAB[v][2*N-1:N];
      @(negedge clk);
      vec_we    = 1'b1;
      vec_addr  = AW'(v);
      vec_wdata = {expv[v] ^ ((v == bad_v) ? N'(1) : N'(0)), TAB[v]};
    end
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  task automatic run_seq(input bit poke_start);
    bit done_seen = 0, prev_tc, prev_strobe = 0;
    int chain_k = 0, sc = 0, caps = 0;
    ce_n = 0; fn_n = 0; busy_n = 0; strobe_n = 0;
    tc_bad = 0; mode_bad = 0; strobe_bad = 0; chain_bad = 0;
    @(negedge clk);
    prev_tc = tc;
    start = 1'b1;
    for (int cyc = 0; cyc < 2000 && !done_seen; cyc++) begin
      @(negedge clk);
      start = poke_start && (cyc == 20);
      if (cyc == 0) mis_first = miscompare;
      if (busy) busy_n++;
      if ((tc != prev_tc) && (scan_ce || func_ce)) tc_bad++;
      if (prev_strobe && !func_ce) strobe_bad++;
      if (pi_strobe) strobe_n++;
      if (scan_ce) ce_n++;
      if (func_ce) begin
        fn_n++;
        if (!scan_ce || tc) mode_bad++;
        caps++;
        sc = 0;
      end else if (scan_ce) begin
        if (!tc) mode_bad++;
        if (chain_k < N + 4) begin
          if (scan_in != chain_k[1]) chain_bad++;
          if (chain_k >= N && scan_out != ((chain_k - N) >> 1) % 2) chain_bad++;
          chain_k++;
        end else if (sc < N) begin
          if (caps < V) stim_got[caps][N-1-sc] = scan_in;
          if (caps > 0) resp_got[caps-1][N-1-sc] = scan_out;
          sc++;
        end
      end
      if (done) done_seen = 1;
      prev_tc = tc;
      prev_strobe = pi_strobe;
    end
    timed_out = !done_seen;
    @(negedge clk);
    check(!done && !busy, "R2", "done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic judge(input string tag, input bit exp_mis);
    check(!timed_out, "R2", {tag, " run finished"}, timed_out, 0);
    check(busy_n == BUSY_TOTAL, "R2", {tag, " busy cycles"}, busy_n, BUSY_TOTAL);
    check(ce_n == CE_TOTAL, "R3", {tag, " scan enable cycles"}, ce_n, CE_TOTAL);
    check(fn_n == V && mode_bad == 0, "R4", {tag, " captures / mode"}, fn_n * 100 + mode_bad, V * 100);
    check(tc_bad == 0, "R5", {tag, " tc changed under enable"}, tc_bad, 0);
    check(chain_bad == 0, "R6", {tag, " chain pattern"}, chain_bad, 0);
    check(strobe_n == V && strobe_bad == 0, "R8", {tag, " strobes"}, strobe_n * 100 + strobe_bad, V * 100);
    for (int v = 0; v < V; v++) begin
      check(stim_got[v] == TAB[v][N-1:0], "R7", $sformatf("%s stimulus %0d", tag, v),
            stim_got[v], TAB[v][N-1:0]);
      check(resp_got[v] == expv[v], v == V - 1 ? "R10" : "R9",
            $sformatf("%s response %0d", tag, v), resp_got[v], expv[v]);
    end
    check(mis_first == 1'b0, "R11", {tag, " flag cleared at start"}, mis_first, 0);
    check(miscompare == exp_mis, "R11", {tag, " miscompare"}, miscompare, exp_mis);
  endtask

  initial begin
    #(4 * 200000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vec_we = 1'b0; vec_addr = '0; vec_wdata = '0;
    nmod = '0;
    @(negedge clk);
    check(!busy && !done && !scan_ce && !func_ce && !pi_strobe && tc && !miscompare,
          "R1", "state in reset",
          {busy, done, scan_ce, func_ce, pi_strobe, tc, miscompare}, 7'b0000010);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !scan_ce && !func_ce && !pi_strobe && tc && !miscompare,
          "R1", "state after release",
          {busy, done, scan_ce, func_ce, pi_strobe, tc, miscompare}, 7'b0000010);

    // run 1: clean vectors, bank starts at zero
    load_vectors(-1);
    run_seq(1'b0);
    judge("run1", 1'b0);

    // run 2: bank carried over (R9), one wrong expected bit, stray start (R12)
    load_vectors(2);
    run_seq(1'b1);
    judge("run2", 1'b1);
    check(ce_n == CE_TOTAL && busy_n == BUSY_TOTAL, "R12", "start while busy ignored",
          ce_n, CE_TOTAL);
    repeat (3) @(negedge clk);
    check(miscompare == 1'b1, "R11", "flag sticky while idle", miscompare, 1);

    // run 3: correct expectations again, start clears the flag
    load_vectors(-1);
    run_seq(1'b0);
    judge("run3", 1'b0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule